// File: doc/BRIEF.md
# Fractional-Rate Serial Transmitter with Break and Idle Gap

This block turns bytes into an asynchronous serial bit stream on one output line. A byte is handed over with a valid/ready handshake. The frame is then sent as a start bit, five to eight data bits least significant first, an optional parity bit and a stop field of one, one and a half or two bit times. The bit time is set by a divisor with an integer part and a four-bit fraction in sixteenths. A small accumulator spreads the fraction, so some bit times are one clock longer than others.

When the last queued byte has gone out, the block raises a one-cycle completion pulse. It can then drive the line low for a programmed number of bit times (a break), and after that hold the line high for a programmed number of bit times (an idle gap). Each of these two phases ends with its own pulse. The current sequencer state is output as a four-bit code, and one configuration bit inverts the line.

Top module: `frac_uart_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `state_code` is 0, `in_ready` is 1, all three done pulses are 0, and `txd` is high (before inversion).
- R2: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while `state_code` is 0 (idle), and the cycle after the handshake `state_code` is 1 (start).
- R3: The start bit is low with code 1. It is followed by 5 + `cfg_len` data bits sent least significant bit first, where data bit k has code 2 + k.
- R4: When `cfg_par_en` is 1, one parity bit with code 10 follows the data. It makes the count of ones in data plus parity even when `cfg_par_odd` is 0, and odd when it is 1.
- R5: Stop bits are high. Code 11 always lasts one full bit time. `cfg_stop` = 3 adds a full second stop bit with code 12. `cfg_stop` = 2 adds a code-12 half bit lasting floor(P/2) clocks, where P is that bit time's period. `cfg_stop` values 0 and 1 give one stop bit.
- R6: Every bit time that begins (including a half stop bit and each bit of a break or gap) first adds `cfg_div_frac` to a 4-bit accumulator that is cleared at reset. Its period is `cfg_div_int` plus the carry out of that addition. Any 16 consecutive full bit times therefore total 16·int + frac clocks.
- R7: A `cfg_div_int` value below 2 is treated as 2.
- R8: If `in_valid` is low when the final stop bit ends, `tx_done` is high for exactly the first cycle afterwards. If `in_valid` is high at that point, the block returns to code 0 for exactly one cycle, takes the next byte and gives no `tx_done`.
- R9: After `tx_done`, when `cfg_brk_en` is 1 and `cfg_brk_len` is nonzero, the line is low with code 13 for `cfg_brk_len` bit times, and `brk_done` is high in the first cycle after that. Otherwise no break and no `brk_done` occur.
- R10: After the break (or after `tx_done` if there is none), the line is high with code 14 for `cfg_idle_len` bit times. `idle_done` is high in the first following cycle, in which the code is 0. With a zero length, `idle_done` rises together with the preceding done pulse.
- R11: `cfg_inv` = 1 inverts `txd` in every state.
- R12: `state_code` uses 0 idle, 1 start, 2 to 9 data bits 0 to 7, 10 parity, 11 first stop, 12 second or half stop, 13 break, 14 idle gap, and never shows 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div_int | input | DIV_INT_W | Integer part of clocks per bit |
| cfg_div_frac | input | DIV_FRAC_W | Fractional part of clocks per bit, in sixteenths |
| cfg_len | input | 2 | Data length code, bits = 5 + code |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | Parity sense, 0 even, 1 odd |
| cfg_stop | input | 2 | Stop field code |
| cfg_brk_en | input | 1 | Send a break after the queue drains |
| cfg_brk_len | input | BRK_W | Break length in bit times |
| cfg_idle_len | input | IDLE_W | Idle gap length in bit times |
| cfg_inv | input | 1 | Invert the line output |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte can be taken |
| in_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line |
| state_code | output | 4 | Sequencer state code |
| tx_done | output | 1 | All taken bytes have been sent |
| brk_done | output | 1 | Break finished |
| idle_done | output | 1 | Idle gap finished |

## Verification
The hardest case to reach is the back-to-back path. Here the next byte must already be offered at the exact edge where the last stop bit ends, so that the block makes its single-cycle pass through idle and suppresses `tx_done`. The stimulus loads the second byte while the first frame is still running and keeps `in_valid` high until it sees the idle cycle. The accumulator also carries its remainder across frames. For that reason the bench keeps its own running model of the fraction from reset onwards and predicts the length of every segment, including half stop bits and multi-bit breaks.

// File: rtl/ftx_pkg.sv
package ftx_pkg;

   localparam int unsigned FTX_DATA_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_START = 4'd1,
      ST_D0    = 4'd2,
      ST_D1    = 4'd3,
      ST_D2    = 4'd4,
      ST_D3    = 4'd5,
      ST_D4    = 4'd6,
      ST_D5    = 4'd7,
      ST_D6    = 4'd8,
      ST_D7    = 4'd9,
      ST_PAR   = 4'd10,
      ST_STOP1 = 4'd11,
      ST_STOP2 = 4'd12,
      ST_BRK   = 4'd13,
      ST_GAP   = 4'd14
   } ftx_state_e;

   typedef enum logic [1:0] {
      STOP_DEF  = 2'd0,
      STOP_ONE  = 2'd1,
      STOP_HALF = 2'd2,
      STOP_TWO  = 2'd3
   } ftx_stop_e;

endpackage

// File: rtl/ftx_baud.sv
// Bit-time generator: one period is loaded per bit time begun, and the
// fraction is spread by a carry accumulator.
module ftx_baud #(
   parameter int unsigned DIV_INT_W  = 20,
   parameter int unsigned DIV_FRAC_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  run,
   input  logic                  half_sel,
   input  logic [DIV_INT_W-1:0]  div_int,
   input  logic [DIV_FRAC_W-1:0] div_frac,
   output logic                  bit_end
);

   localparam int unsigned PW = DIV_INT_W + 1;
   localparam logic [DIV_INT_W-1:0] MIN_INT = DIV_INT_W'(2);

   logic [DIV_FRAC_W-1:0] acc_q;
   logic [DIV_FRAC_W:0]   sum;
   logic [DIV_INT_W-1:0]  eff_int;
   logic [PW-1:0]         per_q;
   logic [PW-1:0]         cnt_q;
   logic [PW-1:0]         lim;

   assign sum     = {1'b0, acc_q} + {1'b0, div_frac};
   assign eff_int = (div_int < MIN_INT) ? MIN_INT : div_int;
   assign lim     = half_sel ? (per_q >> 1) : per_q;
   assign bit_end = run && (cnt_q == lim - PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         per_q <= PW'(2);
         cnt_q <= '0;
      end else if (load) begin
         acc_q <= sum[DIV_FRAC_W-1:0];
         per_q <= {1'b0, eff_int} + PW'(sum[DIV_FRAC_W]);
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= bit_end ? '0 : cnt_q + PW'(1);
      end
   end

endmodule

// File: rtl/ftx_seq.sv
// Frame sequencer: walks start, data, parity and stop states, then the
// break and gap phases once the queue is empty.
module ftx_seq
   import ftx_pkg::*;
#(
   parameter int unsigned BRK_W  = 8,
   parameter int unsigned IDLE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic [1:0]        cfg_stop,
   input  logic              cfg_brk_en,
   input  logic [BRK_W-1:0]  cfg_brk_len,
   input  logic [IDLE_W-1:0] cfg_idle_len,
   input  logic              bit_end,
   output ftx_state_e        state_q,
   output logic              accept,
   output logic              load,
   output logic              half_sel,
   output logic              tx_done,
   output logic              brk_done,
   output logic              idle_done
);

   localparam int unsigned CNT_W = (BRK_W > IDLE_W) ? BRK_W : IDLE_W;

   ftx_state_e       state_d;
   ftx_state_e       last_data;
   ftx_state_e       drain_st;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] brk_last, gap_last;
   logic             drain_tx, drain_idle;
   logic             tx_p, brk_p, idle_p;
   logic             brk_on, gap_on;

   assign accept    = in_valid && (state_q == ST_IDLE);
   assign last_data = ftx_state_e'(4'(ST_D0) + {2'b00, cfg_len} + 4'd4);
   assign brk_on    = cfg_brk_en && (cfg_brk_len != '0);
   assign gap_on    = (cfg_idle_len != '0);
   assign brk_last  = CNT_W'(cfg_brk_len) - CNT_W'(1);
   assign gap_last  = CNT_W'(cfg_idle_len) - CNT_W'(1);
   assign half_sel  = (state_q == ST_STOP2) && (cfg_stop == STOP_HALF);

   // Where the line goes after the final stop bit
   always_comb begin
      drain_tx   = 1'b1;
      drain_idle = 1'b0;
      if (in_valid) begin
         drain_st = ST_IDLE;
         drain_tx = 1'b0;
      end else if (brk_on) begin
         drain_st = ST_BRK;
      end else if (gap_on) begin
         drain_st = ST_GAP;
      end else begin
         drain_st   = ST_IDLE;
         drain_idle = 1'b1;
      end
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      tx_p    = 1'b0;
      brk_p   = 1'b0;
      idle_p  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (in_valid) state_d = ST_START;
         end
         ST_START: begin
            if (bit_end) state_d = ST_D0;
         end
         ST_PAR: begin
            if (bit_end) state_d = ST_STOP1;
         end
         ST_STOP1: begin
            if (bit_end) begin
               if (cfg_stop == STOP_HALF || cfg_stop == STOP_TWO) begin
                  state_d = ST_STOP2;
               end else begin
                  state_d = drain_st;
                  tx_p    = drain_tx;
                  idle_p  = drain_idle;
                  cnt_d   = '0;
               end
            end
         end
         ST_STOP2: begin
            if (bit_end) begin
               state_d = drain_st;
               tx_p    = drain_tx;
               idle_p  = drain_idle;
               cnt_d   = '0;
            end
         end
         ST_BRK: begin
            if (bit_end) begin
               if (cnt_q == brk_last) begin
                  brk_p = 1'b1;
                  cnt_d = '0;
                  if (gap_on) begin
                     state_d = ST_GAP;
                  end else begin
                     state_d = ST_IDLE;
                     idle_p  = 1'b1;
                  end
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
         end
         ST_GAP: begin
            if (bit_end) begin
               if (cnt_q == gap_last) begin
                  state_d = ST_IDLE;
                  idle_p  = 1'b1;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + CNT_W'(1);
               end
            end
         end
         default: begin
            if (bit_end) begin
               if (state_q == last_data) begin
                  state_d = cfg_par_en ? ST_PAR : ST_STOP1;
               end else begin
                  state_d = ftx_state_e'(4'(state_q) + 4'd1);
               end
            end
         end
      endcase
   end

   assign load = (state_d != ST_IDLE) && (accept || bit_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         tx_done   <= 1'b0;
         brk_done  <= 1'b0;
         idle_done <= 1'b0;
      end else begin
         state_q   <= state_d;
         cnt_q     <= cnt_d;
         tx_done   <= tx_p;
         brk_done  <= brk_p;
         idle_done <= idle_p;
      end
   end

endmodule

// File: rtl/ftx_line.sv
// Line driver: captures the byte and its parity, then picks the level
// for the current state.
module ftx_line
   import ftx_pkg::*;
#(
   parameter int unsigned DATA_W = FTX_DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_odd,
   input  logic              cfg_inv,
   input  ftx_state_e        state,
   output logic              txd
);

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] data_q;
   logic              par_q;
   logic              par_calc;
   logic              raw;
   logic [3:0]        idx;

   for (genvar g = 0; g < DATA_W; g++) begin : g_mask
      assign mask[g] = (4'(g) < (4'd5 + {2'b00, cfg_len}));
   end

   assign par_calc = (^(in_data & mask)) ^ cfg_par_odd;
   assign idx      = 4'(state) - 4'(ST_D0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         par_q  <= 1'b0;
      end else if (accept) begin
         data_q <= in_data;
         par_q  <= par_calc;
      end
   end

   always_comb begin
      unique case (state)
         ST_START, ST_BRK: raw = 1'b0;
         ST_PAR:           raw = par_q;
         ST_D0, ST_D1, ST_D2, ST_D3,
         ST_D4, ST_D5, ST_D6, ST_D7: raw = data_q[idx[2:0]];
         default:          raw = 1'b1;
      endcase
   end

   assign txd = raw ^ cfg_inv;

endmodule

// File: rtl/frac_uart_tx.sv
module frac_uart_tx
   import ftx_pkg::*;
#(
   parameter int unsigned DIV_INT_W  = 20,
   parameter int unsigned DIV_FRAC_W = 4,
   parameter int unsigned BRK_W      = 8,
   parameter int unsigned IDLE_W     = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DIV_INT_W-1:0]  cfg_div_int,
   input  logic [DIV_FRAC_W-1:0] cfg_div_frac,
   input  logic [1:0]            cfg_len,
   input  logic                  cfg_par_en,
   input  logic                  cfg_par_odd,
   input  logic [1:0]            cfg_stop,
   input  logic                  cfg_brk_en,
   input  logic [BRK_W-1:0]      cfg_brk_len,
   input  logic [IDLE_W-1:0]     cfg_idle_len,
   input  logic                  cfg_inv,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [7:0]            in_data,
   output logic                  txd,
   output logic [3:0]            state_code,
   output logic                  tx_done,
   output logic                  brk_done,
   output logic                  idle_done
);

   if (DIV_INT_W < 2) begin : g_bad_int
      $error("DIV_INT_W must be at least 2");
   end
   if (DIV_FRAC_W < 1 || DIV_FRAC_W > 8) begin : g_bad_frac
      $error("DIV_FRAC_W must be 1 to 8");
   end
   if (BRK_W < 1 || IDLE_W < 1) begin : g_bad_len
      $error("BRK_W and IDLE_W must be nonzero");
   end

   ftx_state_e state;
   logic       accept;
   logic       load;
   logic       half_sel;
   logic       bit_end;

   ftx_baud #(
      .DIV_INT_W  (DIV_INT_W),
      .DIV_FRAC_W (DIV_FRAC_W)
   ) i_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .run      (state != ST_IDLE),
      .half_sel (half_sel),
      .div_int  (cfg_div_int),
      .div_frac (cfg_div_frac),
      .bit_end  (bit_end)
   );

   ftx_seq #(
      .BRK_W  (BRK_W),
      .IDLE_W (IDLE_W)
   ) i_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .cfg_len      (cfg_len),
      .cfg_par_en   (cfg_par_en),
      .cfg_stop     (cfg_stop),
      .cfg_brk_en   (cfg_brk_en),
      .cfg_brk_len  (cfg_brk_len),
      .cfg_idle_len (cfg_idle_len),
      .bit_end      (bit_end),
      .state_q      (state),
      .accept       (accept),
      .load         (load),
      .half_sel     (half_sel),
      .tx_done      (tx_done),
      .brk_done     (brk_done),
      .idle_done    (idle_done)
   );

   ftx_line #(
      .DATA_W (FTX_DATA_W)
   ) i_line (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .in_data     (in_data),
      .cfg_len     (cfg_len),
      .cfg_par_odd (cfg_par_odd),
      .cfg_inv     (cfg_inv),
      .state       (state),
      .txd         (txd)
   );

   assign in_ready   = (state == ST_IDLE);
   assign state_code = 4'(state);

endmodule

// File: rtl/ftx_chk.sv
module ftx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_ready,
   input logic       cfg_inv,
   input logic [3:0] state_code,
   input logic       txd,
   input logic       tx_done,
   input logic       brk_done,
   input logic       idle_done,
   input logic       bit_end
);

   AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> state_code == 4'd1); // R2

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      state_code == 4'd1 |-> txd == cfg_inv); // R3

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      state_code == 4'd0 |-> txd == !cfg_inv); // R11

   AST_TXDONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> ($past(state_code) == 4'd11 || $past(state_code) == 4'd12)); // R8

   AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      state_code == 4'd13 |-> txd == cfg_inv); // R9

   AST_BRKDONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |-> $past(state_code) == 4'd13); // R9

   AST_IDLEDONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_done |-> state_code == 4'd0); // R10

   AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_done, brk_done})); // R8

   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_ready) && !bit_end |=> $stable(state_code)); // R6

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      state_code != 4'd15); // R12

endmodule

bind frac_uart_tx ftx_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .cfg_inv    (cfg_inv),
   .state_code (state_code),
   .txd        (txd),
   .tx_done    (tx_done),
   .brk_done   (brk_done),
   .idle_done  (idle_done),
   .bit_end    (bit_end)
);

// File: tb/test_frac_uart_tx.sv
`timescale 1ns/1ps
module test_frac_uart_tx;

   typedef struct packed {
      logic [7:0]  data;
      logic [1:0]  len;
      logic        par_en;
      logic        par_odd;
      logic [1:0]  stop;
      logic [19:0] dint;
      logic [3:0]  frac;
      logic        inv;
      logic        brk_en;
      logic [7:0]  brk_len;
      logic [9:0]  idle_len;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'hA5, 2'd3, 1'b0, 1'b0, 2'd1, 20'd4, 4'd0,  1'b0, 1'b0, 8'd0, 10'd0},
      '{8'h3C, 2'd0, 1'b1, 1'b0, 2'd3, 20'd5, 4'd8,  1'b0, 1'b0, 8'd0, 10'd0},
      '{8'h5A, 2'd1, 1'b1, 1'b1, 2'd2, 20'd6, 4'd3,  1'b0, 1'b0, 8'd0, 10'd0},
      '{8'hFF, 2'd2, 1'b1, 1'b0, 2'd2, 20'd7, 4'd15, 1'b1, 1'b0, 8'd0, 10'd0},
      '{8'h81, 2'd3, 1'b1, 1'b1, 2'd1, 20'd3, 4'd5,  1'b0, 1'b1, 8'd3, 10'd2},
      '{8'h00, 2'd3, 1'b0, 1'b0, 2'd3, 20'd1, 4'd0,  1'b0, 1'b1, 8'd0, 10'd3},
      '{8'h96, 2'd3, 1'b1, 1'b0, 2'd2, 20'd2, 4'd9,  1'b1, 1'b1, 8'd2, 10'd0},
      '{8'h6E, 2'd2, 1'b0, 1'b0, 2'd0, 20'd4, 4'd1,  1'b0, 1'b0, 8'd5, 10'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] cfg_div_int = '0;
   logic [3:0]  cfg_div_frac = '0;
   logic [1:0]  cfg_len = '0;
   logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
   logic [1:0]  cfg_stop = '0;
   logic        cfg_brk_en = 1'b0;
   logic [7:0]  cfg_brk_len = '0;
   logic [9:0]  cfg_idle_len = '0;
   logic        cfg_inv = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_ready, txd, tx_done, brk_done, idle_done;
   logic [3:0]  state_code;

   int checks = 0;
   int errors = 0;
   int acc_m = 0;
   int ns = 0;
   int s_code [64];
   int s_lvl  [64];
   int s_dur  [64];
   int s_flg  [64];
   int m_dur  [64];

   always #4 clk = ~clk;   // 125 MHz

   frac_uart_tx i_frac_uart_tx (
      .clk(clk), .rst_n(rst_n),
      .cfg_div_int(cfg_div_int), .cfg_div_frac(cfg_div_frac),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_stop(cfg_stop), .cfg_brk_en(cfg_brk_en), .cfg_brk_len(cfg_brk_len),
      .cfg_idle_len(cfg_idle_len), .cfg_inv(cfg_inv),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .txd(txd), .state_code(state_code),
      .tx_done(tx_done), .brk_done(brk_done), .idle_done(idle_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic string tag(input int c);
      if (c == 0)  return "R8";
      if (c <= 9)  return "R3";
      if (c == 10) return "R4";
      if (c <= 12) return "R5";
      if (c == 13) return "R9";
      return "R10";
   endfunction

   // R6 R7: next bit period from the running fraction model
   function automatic int nxt(input int dint, input int frac);
      int e = (dint < 2) ? 2 : dint;
      int s = acc_m + frac;
      acc_m = s % 16;
      return e + s / 16;
   endfunction

   task automatic add_seg(input int c, input int l, input int d, input int f);
      s_code[ns] = c; s_lvl[ns] = l; s_dur[ns] = d; s_flg[ns] = f;
      ns++;
   endtask

   task automatic apply_cfg(input vec_t v);
      cfg_div_int = v.dint; cfg_div_frac = v.frac; cfg_len = v.len;
      cfg_par_en = v.par_en; cfg_par_odd = v.par_odd; cfg_stop = v.stop;
      cfg_brk_en = v.brk_en; cfg_brk_len = v.brk_len;
      cfg_idle_len = v.idle_len; cfg_inv = v.inv;
   endtask

   // Expected segments; flags bit0 tx_done, bit1 brk_done, bit2 idle_done
   task automatic build(input vec_t v, input bit more);
      int inv = int'(v.inv);
      int n = 5 + int'(v.len);
      int p = int'(v.par_odd);
      int d;
      add_seg(1, inv, nxt(v.dint, v.frac), 0);
      for (int k = 0; k < n; k++) begin
         add_seg(2 + k, int'(v.data[k]) ^ inv, nxt(v.dint, v.frac), 0);
         p = p ^ int'(v.data[k]);
      end
      if (v.par_en) add_seg(10, p ^ inv, nxt(v.dint, v.frac), 0);
      add_seg(11, 1 ^ inv, nxt(v.dint, v.frac), 0);
      if (v.stop == 2'd2) add_seg(12, 1 ^ inv, nxt(v.dint, v.frac) / 2, 0);
      if (v.stop == 2'd3) add_seg(12, 1 ^ inv, nxt(v.dint, v.frac), 0);
      if (more) begin
         add_seg(0, 1 ^ inv, 1, 0);
      end else begin
         s_flg[ns-1] = 1;
         if (v.brk_en && v.brk_len != 0) begin
            d = 0;
            for (int k = 0; k < int'(v.brk_len); k++) d += nxt(v.dint, v.frac);
            add_seg(13, inv, d, (v.idle_len == 0) ? 6 : 2);
         end else if (v.idle_len == 0) begin
            s_flg[ns-1] = 5;
         end
         if (v.idle_len != 0) begin
            d = 0;
            for (int k = 0; k < int'(v.idle_len); k++) d += nxt(v.dint, v.frac);
            add_seg(14, 1 ^ inv, d, 4);
         end
      end
   endtask

   task automatic observe(input int inv);
      for (int i = 0; i < ns; i++) begin
         int d = 0;
         bit lvl_ok = 1'b1;
         bit rdy_ok = 1'b1;
         while (int'(state_code) == s_code[i] && d < 20000) begin
            if (int'(txd) != s_lvl[i]) lvl_ok = 1'b0;
            if (in_ready != (s_code[i] == 0)) rdy_ok = 1'b0;
            d++;
            @(negedge clk);
         end
         m_dur[i] = d;
         chk(d == s_dur[i], {tag(s_code[i]), " R6 R12 segment length, code ",
             $sformatf("%0d", s_code[i])}, d, s_dur[i]);
         chk(lvl_ok, {tag(s_code[i]), " R11 line level"}, int'(txd), s_lvl[i]);
         chk(rdy_ok, "R2 ready only in idle", int'(in_ready), int'(s_code[i] == 0));
         chk(tx_done == s_flg[i][0], "R8 tx_done", int'(tx_done), s_flg[i] & 1);
         chk(brk_done == s_flg[i][1], "R9 brk_done", int'(brk_done), (s_flg[i] >> 1) & 1);
         chk(idle_done == s_flg[i][2], "R10 idle_done", int'(idle_done), (s_flg[i] >> 2) & 1);
      end
      chk(state_code == 4'd0 && int'(txd) == (1 ^ inv), "R1 R11 back to idle level",
          int'(txd), 1 ^ inv);
   endtask

   task automatic send(input vec_t v);
      @(negedge clk);
      apply_cfg(v);
      in_valid = 1'b1;
      in_data  = v.data;
      ns = 0;
      build(v, 1'b0);
      @(negedge clk);
      in_valid = 1'b0;
      chk(state_code == 4'd1, "R2 start after handshake", int'(state_code), 1);
      observe(int'(v.inv));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      vec_t v, v2;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(state_code == 4'd0 && in_ready && txd, "R1 reset outputs",
          int'({state_code, in_ready, txd}), 3);
      chk(!tx_done && !brk_done && !idle_done, "R1 done pulses low", 
          int'({tx_done, brk_done, idle_done}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(state_code == 4'd0 && in_ready && txd, "R1 first cycle after reset",
          int'({state_code, in_ready, txd}), 3);

      // Vector walk: R3 R4 R5 R6 R7 R9 R10 R11
      for (int i = 0; i < NV; i++) send(VECS[i]);

      // R6: 16-bit gap totals 16*int + frac
      v = '{8'h11, 2'd3, 1'b0, 1'b0, 2'd1, 20'd3, 4'd5, 1'b0, 1'b0, 8'd0, 10'd16};
      send(v);
      chk(m_dur[ns-1] == 16 * 3 + 5, "R6 sixteen bit gap", m_dur[ns-1], 53);

      // R8: back-to-back frames, single idle cycle and no tx_done between
      v  = '{8'hC3, 2'd3, 1'b1, 1'b0, 2'd2, 20'd3, 4'd7, 1'b0, 1'b1, 8'd1, 10'd1};
      v2 = v;
      v2.data = 8'h2D;
      @(negedge clk);
      apply_cfg(v);
      in_valid = 1'b1;
      in_data  = v.data;
      ns = 0;
      build(v, 1'b1);
      build(v2, 1'b0);
      @(negedge clk);
      in_data = v2.data;
      chk(state_code == 4'd1, "R2 start after handshake", int'(state_code), 1);
      fork
         observe(0);
         begin
            do @(negedge clk); while (state_code != 4'd0);
            @(negedge clk);
            in_valid = 1'b0;
         end
      join

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule